// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A 32-bit counter steps down by one on every selected tick, and on the tick after it reaches zero it takes the reload value and keeps going. The tick comes either from the system clock, which gives one step per cycle, or from a slow external tick-enable input that is synchronous to the system clock. Each lap can raise up to three interrupt events: when the count lands on the larger of the two match thresholds, when it lands on the smaller one, and when it lands on zero. A threshold that is not below the reload value counts as zero, so it adds no event of its own.

Each event inverts the interrupt level output instead of sending a pulse, and it also raises a one-cycle strobe that a shared status register collects. Software writes the count, the reload value and both thresholds through a simple write port. The count output shows the reload value while the channel is disabled and the live count while it is enabled.

Top module: `dmtimer_chan`

## Requirements
- R1: After a synchronous reset the count output, the interrupt level and the event strobe are all zero, and the reload and both thresholds are zero.
- R2: With the tick source at 0 (system clock) and the channel enabled, the count falls by one every cycle. On the cycle after it reaches zero it takes the reload value.
- R3: With the tick source at 1 (external), the count changes only at the clock edges where ext_tick is high. It holds on every other edge.
- R4: While the channel is enabled, an event fires when a decrement lands on the larger effective threshold and again when it lands on the smaller one. This holds whichever of the two threshold registers carries which value.
- R5: A threshold that is greater than or equal to the reload value is treated as zero and produces no event of its own.
- R6: A decrement that lands on zero fires an event only when ovf_irq_en is high or when either threshold register holds zero.
- R7: Each event inverts irq_level and drives evt_strobe high for exactly the cycle after the decrement that caused it.
- R8: While chan_en is low the count output shows the reload value and the count does not advance.
- R9: Write codes on wr_sel are 0 count, 1 reload, 2 threshold A and 3 threshold B. A count write loads the current count when the channel is enabled and is ignored when it is disabled.
- R10: A nonzero reload written while the previous reload is zero and the channel is enabled restarts the count from the written value. A reload written while the previous reload is nonzero leaves the running count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| clk_sel | input | 1 | Tick source: 0 system clock, 1 external tick |
| ext_tick | input | 1 | External tick enable, synchronous to clk |
| ovf_irq_en | input | 1 | Allows the zero-landing event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 reload, 2 threshold A, 3 threshold B |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Live count when enabled, reload value when disabled |
| irq_level | output | 1 | Interrupt level, inverted by each event |
| evt_strobe | output | 1 | One-cycle pulse for each event |

## Verification
The hardest case to reach is a threshold that is ignored even though the count does pass through its value. The stimulus sets up laps where one threshold lies above the reload value, or equals it. It also loads a count far above the reload, so that the decrements cross a raw threshold value that must stay silent. The queue of expected landing values then shows that only the clipped thresholds fire. A second hard case is the restart from a zero reload. The channel is enabled with a zero reload so that it sits stuck at zero, and then a reload write has to start it counting.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int unsigned CNT_W   = 32;
    localparam int unsigned SEL_W   = 2;
    localparam int unsigned N_MATCH = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_COUNT   = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_MATCH_A = 2'd2,
        SEL_MATCH_B = 2'd3
    } wr_sel_e;

    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_EXT = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic hit_hi;
        logic hit_lo;
        logic hit_zero;
    } evt_t;

    // Threshold at or above the reload value collapses to zero.
    function automatic cnt_t clip_match(input cnt_t m, input cnt_t rl);
        return (m < rl) ? m : '0;
    endfunction

    function automatic cnt_t max2(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

    function automatic cnt_t min2(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [SEL_W-1:0] match_code(input int unsigned idx);
        return SEL_W'(int'(SEL_MATCH_A) + idx);
    endfunction

endpackage

// File: rtl/dmt_counter.sv
module dmt_counter
    import dmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  cnt_t             wr_data,
    output cnt_t             cnt_q,
    output cnt_t             reload_q,
    output logic             step,
    output cnt_t             next_val
);

    logic wr_cnt;
    logic wr_rl;
    logic kick;

    always_comb begin
        wr_cnt   = wr_en && (wr_sel == SEL_COUNT) && en;
        wr_rl    = wr_en && (wr_sel == SEL_RELOAD);
        kick     = wr_rl && en && (reload_q == '0) && (wr_data != '0);
        step     = en && tick && !wr_cnt && !kick && (cnt_q != '0);
        next_val = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_rl) begin
            reload_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= wr_rl ? wr_data : reload_q;
        end else if (wr_cnt || kick) begin
            cnt_q <= wr_data;
        end else if (tick) begin
            cnt_q <= (cnt_q == '0) ? reload_q : next_val;
        end
    end

    // R2
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !wr_en && cnt_q == '0) |=> (cnt_q == $past(reload_q)));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !wr_en) |=> $stable(cnt_q));

    // R8
    off_track_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_en) |=> (cnt_q == $past(reload_q)));

endmodule

// File: rtl/dmt_match_unit.sv
module dmt_match_unit
    import dmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  cnt_t             wr_data,
    input  cnt_t             reload_q,
    output cnt_t             hi_eff,
    output cnt_t             lo_eff,
    output logic             any_raw_zero
);

    cnt_t               raw_q [N_MATCH];
    cnt_t               eff   [N_MATCH];
    logic [N_MATCH-1:0] raw_zero;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[i] <= '0;
            end else if (wr_en && (wr_sel == match_code(i))) begin
                raw_q[i] <= wr_data;
            end
        end

        always_comb begin
            eff[i]      = clip_match(raw_q[i], reload_q);
            raw_zero[i] = (raw_q[i] == '0);
        end
    end

    always_comb begin
        hi_eff       = max2(eff[0], eff[1]);
        lo_eff       = min2(eff[0], eff[1]);
        any_raw_zero = |raw_zero;
    end

    // R4
    order_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (hi_eff >= lo_eff));

endmodule

// File: rtl/dmt_event.sv
module dmt_event
    import dmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  cnt_t next_val,
    input  cnt_t hi_eff,
    input  cnt_t lo_eff,
    input  logic any_raw_zero,
    input  logic ovf_en,
    output logic level_q,
    output logic strobe_q
);

    evt_t ev;
    logic fire;

    always_comb begin
        ev.hit_hi   = (hi_eff != '0) && (next_val == hi_eff);
        ev.hit_lo   = (lo_eff != '0) && (next_val == lo_eff);
        ev.hit_zero = (next_val == '0) && (ovf_en || any_raw_zero);
        fire        = step && (|ev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= fire;
            if (fire) begin
                level_q <= ~level_q;
            end
        end
    end

    // R7
    toggle_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> (level_q != $past(level_q)));

    // R7
    quiet_level_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_q |-> $stable(level_q));

    // R6
    zero_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (step && next_val == '0 && !ovf_en && !any_raw_zero) |=> !strobe_q);

endmodule

// File: rtl/dmtimer_chan.sv
module dmtimer_chan
    import dmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        chan_en,
    input  logic        clk_sel,
    input  logic        ext_tick,
    input  logic        ovf_irq_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] count_o,
    output logic        irq_level,
    output logic        evt_strobe
);

    tick_src_e src;
    logic      tick;
    cnt_t      cnt_q;
    cnt_t      reload_q;
    cnt_t      next_val;
    logic      step;
    cnt_t      hi_eff;
    cnt_t      lo_eff;
    logic      any_raw_zero;

    always_comb begin
        src  = tick_src_e'(clk_sel);
        tick = (src == SRC_EXT) ? ext_tick : 1'b1;
    end

    dmt_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .en       (chan_en),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cnt_q    (cnt_q),
        .reload_q (reload_q),
        .step     (step),
        .next_val (next_val)
    );

    dmt_match_unit u_match (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_data      (wr_data),
        .reload_q     (reload_q),
        .hi_eff       (hi_eff),
        .lo_eff       (lo_eff),
        .any_raw_zero (any_raw_zero)
    );

    dmt_event u_event (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .next_val     (next_val),
        .hi_eff       (hi_eff),
        .lo_eff       (lo_eff),
        .any_raw_zero (any_raw_zero),
        .ovf_en       (ovf_irq_en),
        .level_q      (irq_level),
        .strobe_q     (evt_strobe)
    );

    assign count_o = chan_en ? cnt_q : reload_q;

    // R5
    match_below_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_strobe && $past(!wr_en) && cnt_q != '0) |-> (cnt_q < reload_q));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (cnt_q == '0 && reload_q == '0 && !irq_level && !evt_strobe));

endmodule

// File: tb/dmtimer_chan_bench.sv
module dmtimer_chan_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_en = 1'b0;
    logic        clk_sel = 1'b0;
    logic        ext_tick = 1'b0;
    logic        ovf_irq_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] count_o;
    logic        irq_level;
    logic        evt_strobe;

    int          tests = 0;
    int          fails = 0;
    logic [31:0] exp_q[$];
    logic        exp_level = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmtimer_chan u_dmtimer_chan (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .clk_sel    (clk_sel),
        .ext_tick   (ext_tick),
        .ovf_irq_en (ovf_irq_en),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .count_o    (count_o),
        .irq_level  (irq_level),
        .evt_strobe (evt_strobe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_evt(input logic [31:0] v);
        exp_q.push_back(v);
        exp_level = ~exp_level;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: every strobe pops one expected landing value.
    always @(negedge clk) begin
        if (!rst && evt_strobe) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected event", count_o, 32'hFFFF_FFFF);
            end else begin
                chk("R4 event landing", count_o, exp_q.pop_front());
            end
        end
    end

    task automatic run_lap(input string req, input logic [31:0] rl,
                           input logic [31:0] ma, input logic [31:0] mb, input logic ovf);
        ovf_irq_en = ovf;
        wr(2'd2, ma);
        wr(2'd3, mb);
        wr(2'd1, rl);
        chan_en = 1'b1;
        repeat (rl + 1) @(posedge clk);
        @(negedge clk);
        chan_en = 1'b0;
        repeat (2) @(negedge clk);
        chk({req, " leftover events"}, exp_q.size(), 0);
        chk("R7 irq level parity", {31'd0, irq_level}, {31'd0, exp_level});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 count", count_o, 0);
        chk("R1 level", {31'd0, irq_level}, 0);
        chk("R1 strobe", {31'd0, evt_strobe}, 0);

        // R8: disabled shows reload, R9: count write ignored when disabled
        wr(2'd2, 32'd3);
        wr(2'd3, 32'd7);
        wr(2'd1, 32'd10);
        chk("R8 disabled shows reload", count_o, 10);
        wr(2'd0, 32'd5);
        chk("R9 count write ignored when off", count_o, 10);
        repeat (3) @(negedge clk);
        chk("R8 no advance when off", count_o, 10);

        // R4: larger then smaller then zero
        push_evt(7); push_evt(3); push_evt(0);
        run_lap("R4", 10, 3, 7, 1'b1);
        // R4: registers swapped, same events
        push_evt(7); push_evt(3); push_evt(0);
        run_lap("R4 swapped", 10, 7, 3, 1'b1);
        // R5: threshold above reload ignored, zero gated off (R6)
        push_evt(4);
        run_lap("R5 above", 10, 12, 4, 1'b0);
        // R5: threshold equal to reload ignored
        push_evt(4); push_evt(0);
        run_lap("R5 equal", 10, 10, 4, 1'b1);
        // R6: no enable, nonzero thresholds: no zero event
        push_evt(6); push_evt(2);
        run_lap("R6 gated", 10, 6, 2, 1'b0);
        // R6: zero threshold register unlocks zero event
        push_evt(5); push_evt(0);
        run_lap("R6 raw zero", 10, 0, 5, 1'b0);

        // R2: per-cycle decrement and wrap
        ovf_irq_en = 1'b0;
        wr(2'd2, 32'd9);
        wr(2'd3, 32'd9);
        wr(2'd1, 32'd3);
        chan_en = 1'b1;
        @(negedge clk); chk("R2 step", count_o, 2);
        @(negedge clk); chk("R2 step", count_o, 1);
        @(negedge clk); chk("R2 step", count_o, 0);
        @(negedge clk); chk("R2 wrap", count_o, 3);
        @(negedge clk); chk("R2 after wrap", count_o, 2);
        chan_en = 1'b0;

        // R3: external tick source
        wr(2'd2, 32'd20);
        wr(2'd3, 32'd20);
        wr(2'd1, 32'd5);
        clk_sel = 1'b1;
        chan_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            repeat (3) @(negedge clk);
            chk("R3 hold without tick", count_o, 32'(5 - k));
            ext_tick = 1'b1;
            @(negedge clk);
            ext_tick = 1'b0;
            chk("R3 step on tick", count_o, 32'(4 - k));
        end
        chan_en = 1'b0;
        clk_sel = 1'b0;

        // R9: count write while enabled; R5: raw 15 crossed silently
        wr(2'd2, 32'd15);
        wr(2'd3, 32'd15);
        wr(2'd1, 32'd10);
        chan_en = 1'b1;
        wr(2'd0, 32'd50);
        chk("R9 count load", count_o, 50);
        @(negedge clk); chk("R9 counts from loaded", count_o, 49);
        repeat (36) @(negedge clk);
        chk("R5 passed raw threshold", count_o, 13);
        chan_en = 1'b0;

        // R10: restart from zero reload
        wr(2'd1, 32'd0);
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 stuck at zero", count_o, 0);
        wr(2'd1, 32'd8);
        chk("R10 kick start", count_o, 8);
        @(negedge clk); chk("R10 running", count_o, 7);
        wr(2'd1, 32'd20);
        chk("R10 reload keeps count", count_o, 5);
        chan_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 no stray events", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule